// File: doc/BRIEF.md
# LED Fault Result Capture Unit

This block is the detection-mode datapath of a 16-channel constant-current LED sink. The host shifts an all-ones word into the serial register and copies it into the output latch with the latch strobe, so that every channel is driven. It then holds the active-low output enable low. While enable stays low, a counter in the system-clock domain measures the drive time. Once the settling window has elapsed, the unit samples the per-channel open and short comparator flags on every clock.

When enable returns high, the most recent sample is parallel-loaded into the same shift register that carries display data. The host reads it back on the serial output with the normal shift strobe, in the same bit order as display data. Only one readback is allowed per detection session. A pass that ends before the window has elapsed, or that runs without a full all-ones latch, yields an all-zero word and raises a sticky error flag. Leaving detection mode clears the session and rearms it.

Top module: `led_fault_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the serial register, the latch, the session state and the error flag clear, so `sdo` and `drive_short_err` read 0.
- R2: On a clock edge with `shift_stb` high and no result load, the register takes `sdi` into bit 0 and moves every bit up one place. `sdo` is bit N-1. With `shift_stb` low the register holds.
- R3: In a valid pass, bit i of the loaded word is 1 exactly when `open_flag[i]` or `short_flag[i]` was 1 on the last clock edge that saw `oe_n` low. Bit N-1 then appears first on `sdo`.
- R4: If the latch (copied from the register on each edge with `le` high) does not hold all ones while `oe_n` is low, the pass is not qualified. The `oe_n` rise then loads all zeros and sets `drive_short_err`.
- R5: A pass is valid only if `oe_n` was low on at least SETTLE_CYC+1 consecutive edges, where SETTLE_CYC = ceil(SYS_CLK_HZ x SETTLE_NS / 1e9). A shorter pass loads all zeros and sets `drive_short_err`.
- R6: Within one detection session, only the first `oe_n` rise loads the register. Later rises leave its contents and `drive_short_err` unchanged.
- R7: A clock edge with `detect_mode` low clears `drive_short_err` and rearms the session for one new pass.
- R8: An `oe_n` rise while `detect_mode` is low loads nothing.
- R9: When a result load and `shift_stb` fall on the same edge, the load wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| detect_mode | input | 1 | High while the device is in detection mode |
| oe_n | input | 1 | Active-low output enable, synchronous to clk |
| le | input | 1 | Latch strobe, level: copies the register into the latch |
| shift_stb | input | 1 | One-cycle shift strobe per serial bit |
| sdi | input | 1 | Serial data in |
| open_flag | input | N | Per-channel open-line or short-to-ground comparator flag |
| short_flag | input | N | Per-channel shorted-LED or short-to-supply comparator flag |
| sdo | output | 1 | Serial data out, bit N-1 of the register |
| drive_short_err | output | 1 | Sticky flag: the last pass was too short or not qualified |

## Verification
The bench builds the unit with N = 16, SYS_CLK_HZ = 200 MHz and SETTLE_NS = 40, which gives an eight-cycle settling window. That is short enough to place passes exactly one edge below and exactly at the validity boundary. A behavioural model compares `sdo` and the error flag on every clock. Targeted readbacks cover the full 16-bit fault word, the unqualified latch, the repeated pass in one session, enable pulses outside detection mode, and a load that coincides with a shift strobe.

// File: rtl/led_fc_pkg.sv
// Package: shared helpers for the LED fault result capture unit.
// Assumes the clock rate and window are given in Hz and ns.
package led_fc_pkg;

    // Number of clock cycles covering ns nanoseconds, rounded up and never zero.
    function automatic int unsigned settle_cycles(longint unsigned clk_hz,
                                                  longint unsigned ns);
        longint unsigned cyc;
        cyc = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/lfc_fault_merge.sv
// Module: lfc_fault_merge
// Folds the two comparator flags of each channel into one fault bit.
// Assumes both flag vectors are already synchronous to the system clock.
module lfc_fault_merge #(
    parameter int N = 16
) (
    input  logic [N-1:0] open_flag,
    input  logic [N-1:0] short_flag,
    output logic [N-1:0] fault_word
);

    // One OR gate per channel: any fault kind marks the channel.
    for (genvar ch = 0; ch < N; ch++) begin : g_chan
        assign fault_word[ch] = open_flag[ch] | short_flag[ch];
    end

endmodule

// File: rtl/lfc_shift_latch.sv
// Module: lfc_shift_latch
// Serial-in register with a parallel result load, plus the output latch.
// Assumes shift_stb is a single-cycle strobe in the clk domain.
module lfc_shift_latch #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_stb,
    input  logic         sdi,
    input  logic         le,
    input  logic         load,
    input  logic [N-1:0] load_word,
    output logic         sdo,
    output logic         latch_full
);

    logic [N-1:0] sreg;
    logic [N-1:0] latch_q;

    // Serial register: result load first, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n)         sreg <= '0;
        else if (load)      sreg <= load_word;
        else if (shift_stb) sreg <= {sreg[N-2:0], sdi};
    end

    // Output latch: follows the register while le is high.
    always_ff @(posedge clk) begin
        if (!rst_n)  latch_q <= '0;
        else if (le) latch_q <= sreg;
    end

    assign sdo        = sreg[N-1];
    assign latch_full = &latch_q;

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb && !load |=> sreg[0] == $past(sdi));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_stb && !load |=> $stable(sreg));
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sreg == $past(load_word));

endmodule

// File: rtl/lfc_drive_timer.sv
// Module: lfc_drive_timer
// Times the enable-low drive window, samples the fault word once settled,
// and issues a single result load per detection session on the enable rise.
// Assumes oe_n and detect_mode are synchronous to clk.
module lfc_drive_timer #(
    parameter int N          = 16,
    parameter int SETTLE_CYC = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         detect_mode,
    input  logic         oe_n,
    input  logic         latch_full,
    input  logic [N-1:0] fault_word,
    output logic         load,
    output logic [N-1:0] load_word,
    output logic         err
);

    localparam int              CW      = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0]   CNT_TOP = CW'(SETTLE_CYC);

    logic          oe_prev;
    logic [CW-1:0] cnt;
    logic          sampled;
    logic [N-1:0]  sample_word;
    logic          used;
    logic          qualify;

    assign qualify   = detect_mode && !used && latch_full && !oe_n;
    assign load      = detect_mode && !used && oe_n && !oe_prev;
    assign load_word = sampled ? sample_word : '0;

    // Enable history for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_prev <= 1'b1;
        else        oe_prev <= oe_n;
    end

    // Drive-window counter and fault sampling once the window has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            sampled     <= 1'b0;
            sample_word <= '0;
        end else if (!detect_mode || oe_n) begin
            cnt     <= '0;
            sampled <= 1'b0;
        end else if (qualify) begin
            if (cnt == CNT_TOP) begin
                sample_word <= fault_word;
                sampled     <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Session bookkeeping: one load per entry, error on an invalid pass.
    always_ff @(posedge clk) begin
        if (!rst_n || !detect_mode) begin
            used <= 1'b0;
            err  <= 1'b0;
        end else if (load) begin
            used <= 1'b1;
            if (!sampled) err <= 1'b1;
        end
    end

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP);
    a_r5_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sampled) |-> $past(cnt) == CNT_TOP);
    a_r4_err_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(load));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_mode |=> !err && !sampled);

endmodule

// File: rtl/led_fault_capture.sv
// Module: led_fault_capture (top)
// Detection-mode result capture for an N-channel LED sink: measures the
// enable-low drive time, samples the comparator flags and returns them
// through the display shift register.
// Assumes every input is synchronous to clk.
module led_fault_capture
    import led_fc_pkg::*;
#(
    parameter int N          = 16,
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int SETTLE_NS  = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         detect_mode,
    input  logic         oe_n,
    input  logic         le,
    input  logic         shift_stb,
    input  logic         sdi,
    input  logic [N-1:0] open_flag,
    input  logic [N-1:0] short_flag,
    output logic         sdo,
    output logic         drive_short_err
);

    localparam int SETTLE_CYC = settle_cycles(longint'(SYS_CLK_HZ), longint'(SETTLE_NS));

    logic [N-1:0] fault_word;
    logic [N-1:0] load_word;
    logic         load;
    logic         latch_full;

    lfc_fault_merge #(.N(N)) u_merge (
        .open_flag  (open_flag),
        .short_flag (short_flag),
        .fault_word (fault_word)
    );

    lfc_drive_timer #(.N(N), .SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .detect_mode (detect_mode),
        .oe_n        (oe_n),
        .latch_full  (latch_full),
        .fault_word  (fault_word),
        .load        (load),
        .load_word   (load_word),
        .err         (drive_short_err)
    );

    lfc_shift_latch #(.N(N)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_stb  (shift_stb),
        .sdi        (sdi),
        .le         (le),
        .load       (load),
        .load_word  (load_word),
        .sdo        (sdo),
        .latch_full (latch_full)
    );

    a_r8_no_load_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_mode && !shift_stb |=> $stable(sdo));

endmodule

// File: tb/led_fault_capture_test.sv
// Bench for led_fault_capture: behavioural reference model compared on
// every clock, plus targeted readbacks of the result word.
module led_fault_capture_test;

    localparam int N = 16;
    localparam int S = 8;   // 200 MHz x 40 ns, rounded up

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         detect_mode = 1'b0;
    logic         oe_n = 1'b1;
    logic         le = 1'b0;
    logic         shift_stb = 1'b0;
    logic         sdi = 1'b0;
    logic [N-1:0] open_flag = '0;
    logic [N-1:0] short_flag = '0;
    logic         sdo;
    logic         drive_short_err;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit chk_en = 1'b0;

    always #2.5 clk = ~clk;

    led_fault_capture #(.N(N), .SYS_CLK_HZ(200_000_000), .SETTLE_NS(40)) uut (
        .clk(clk), .rst_n(rst_n), .detect_mode(detect_mode), .oe_n(oe_n),
        .le(le), .shift_stb(shift_stb), .sdi(sdi), .open_flag(open_flag),
        .short_flag(short_flag), .sdo(sdo), .drive_short_err(drive_short_err)
    );

    // Reference model state.
    bit           mq[$];   // mq[0] is the bit presented on sdo
    bit           m_latch_ones;
    int           m_low_run;
    bit           m_have;
    logic [N-1:0] m_samp;
    bit           m_used;
    bit           m_err;
    bit           m_oe_last;

    function automatic bit q_all_ones();
        foreach (mq[i]) if (!mq[i]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < N; i++) mq.push_back(1'b0);
            m_latch_ones = 0; m_low_run = 0; m_have = 0; m_samp = '0;
            m_used = 0; m_err = 0; m_oe_last = 1;
        end else begin
            bit rise;
            bit old_ones;
            old_ones = q_all_ones();
            rise = oe_n && !m_oe_last && detect_mode && !m_used;
            if (rise) begin
                logic [N-1:0] w;
                w = m_have ? m_samp : '0;
                mq.delete();
                for (int i = N-1; i >= 0; i--) mq.push_back(w[i]);
                if (!m_have) m_err = 1;
                m_used = 1;
            end else if (shift_stb) begin
                void'(mq.pop_front());
                mq.push_back(sdi);
            end
            if (!detect_mode) begin
                m_low_run = 0; m_have = 0; m_used = 0; m_err = 0;
            end else if (oe_n) begin
                m_low_run = 0; m_have = 0;
            end else if (!m_used && m_latch_ones) begin
                if (m_low_run >= S) begin m_samp = open_flag | short_flag; m_have = 1; end
                else m_low_run++;
            end
            if (le) m_latch_ones = old_ones;
            m_oe_last = oe_n;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            checks++;
            if (sdo !== mq[0] || drive_short_err !== m_err) begin
                errors++;
                $display("FAIL %s per-cycle: sdo=%b err=%b expected sdo=%b err=%b",
                         phase, sdo, drive_short_err, mq[0], m_err);
            end
        end
    end

    task automatic check_val(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write_word(logic [N-1:0] w);
        for (int i = N-1; i >= 0; i--) begin
            sdi = w[i]; shift_stb = 1'b1; @(negedge clk);
        end
        shift_stb = 1'b0; sdi = 1'b0;
    endtask

    task automatic read_word(output logic [N-1:0] got);
        for (int i = N-1; i >= 0; i--) begin
            got[i] = sdo; sdi = 1'b0; shift_stb = 1'b1; @(negedge clk);
        end
        shift_stb = 1'b0;
    endtask

    task automatic do_latch();
        le = 1'b1; @(negedge clk); le = 1'b0;
    endtask

    task automatic do_pass(int low_edges, bit stb_on_rise);
        oe_n = 1'b0;
        repeat (low_edges) @(negedge clk);
        oe_n = 1'b1; shift_stb = stb_on_rise; sdi = 1'b1;
        @(negedge clk);
        shift_stb = 1'b0; sdi = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [N-1:0] got;
        repeat (3) @(negedge clk);
        phase = "R1";
        check_val("R1 sdo after reset", {{(N-1){1'b0}}, sdo}, '0);
        check_val("R1 err after reset", {{(N-1){1'b0}}, drive_short_err}, '0);
        rst_n = 1'b1; chk_en = 1'b1;

        phase = "R2";
        write_word(16'hA5C3);
        repeat (3) @(negedge clk);
        read_word(got);
        check_val("R2 shift and hold", got, 16'hA5C3);

        phase = "R3";
        detect_mode = 1'b1;
        write_word('1); do_latch();
        open_flag = 16'h0013; short_flag = 16'h8400;
        do_pass(S + 4, 1'b0);
        check_val("R3 err clear", {{(N-1){1'b0}}, drive_short_err}, '0);
        read_word(got);
        check_val("R3 fault word", got, 16'h8413);

        phase = "R6";
        write_word('1);
        open_flag = 16'h0F0F; short_flag = '0;
        do_pass(S + 4, 1'b0);
        read_word(got);
        check_val("R6 second rise no reload", got, 16'hFFFF);

        phase = "R8";
        detect_mode = 1'b0; @(negedge clk);
        write_word('1);
        do_pass(S + 4, 1'b0);
        read_word(got);
        check_val("R8 no load outside detection", got, 16'hFFFF);

        phase = "R5";
        detect_mode = 1'b1;
        write_word('1); do_latch();
        open_flag = 16'h1234; short_flag = 16'h4000;
        do_pass(S, 1'b0);
        check_val("R5 short pass err", {{(N-1){1'b0}}, drive_short_err}, 16'h0001);
        read_word(got);
        check_val("R5 short pass zero word", got, '0);

        phase = "R7";
        detect_mode = 1'b0; @(negedge clk);
        check_val("R7 err cleared", {{(N-1){1'b0}}, drive_short_err}, '0);

        phase = "R9";
        detect_mode = 1'b1;
        write_word('1); do_latch();
        do_pass(S + 1, 1'b1);
        check_val("R5 boundary pass err", {{(N-1){1'b0}}, drive_short_err}, '0);
        read_word(got);
        check_val("R9 load beats shift, R5 boundary", got, 16'h5234);

        phase = "R4";
        detect_mode = 1'b0; @(negedge clk);
        detect_mode = 1'b1;
        write_word(16'hFFFE); do_latch();
        do_pass(S + 4, 1'b0);
        check_val("R4 unqualified err", {{(N-1){1'b0}}, drive_short_err}, 16'h0001);
        read_word(got);
        check_val("R4 unqualified zero word", got, '0);

        chk_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule